// File: doc/BRIEF.md
# Scan-Carried Character Channel

This block carries a byte stream in both directions between a debug host and the target. The host reaches it through a JTAG data register while this debug module is selected. Two byte FIFOs sit inside. The host fills one and the target reads it. The target fills the other and the host drains it. On the target side there is a plain byte port: a read strobe with its data, a write strobe with its data, and flags for an empty receive FIFO and a full transmit FIFO.

One scan is always 72 bits long. It is a header byte followed by eight byte slots. In the header the block sends, the high nibble gives how many target bytes fill the slots, and the low nibble gives the room left in the host-to-target FIFO. In the header the host sends, the high nibble gives how many host bytes follow. The block stores only the smaller of that count and the room it reported. The host assumes exactly that number was accepted.

The capture, shift and update strobes are single-cycle pulses in the block's clock domain, and they come from an external TAP controller. The block only consumes bytes from the transmit FIFO when a scan completes its full length. A scan that is cut short therefore loses nothing.

Top module: `jtag_char_port`

## Requirements
- R1: At capture the block latches an outgoing header whose bits 7:4 hold min(transmit FIFO fill, 8) and whose bits 3:0 hold min(receive FIFO free space, 15).
- R2: A scan is 72 bits. The header byte goes first, then slot 0 up to slot 7, each byte least significant bit first. `tdo` shows the bit about to be shifted out. Slot k holds the k-th oldest transmit byte when k is below the header count, and zero otherwise.
- R3: At update after exactly 72 shifts, the incoming bits 7:4 give the host count. The block stores min(host count, latched free space, 8) bytes from the slots in slot order and discards the rest.
- R4: The offered transmit bytes are removed only by an update that follows exactly 72 shifts since capture. An update after any other shift count leaves both FIFOs unchanged.
- R5: `rd_data` shows the oldest byte in the receive FIFO, and `rd_en` advances to the next byte. Bytes come out in the order the host sent them.
- R6: A read while `rx_empty` is high and a write while `tx_full` is high are ignored. `rx_empty` is high when the receive FIFO is empty, and `tx_full` is high when the transmit FIFO holds DEPTH bytes.
- R7: While `sel` is low, capture, shift and update have no effect and `tdo` is 0.
- R8: After reset both FIFOs are empty, `rx_empty` is 1, `tx_full` is 0 and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | This module is the selected debug module |
| capture | input | 1 | Capture strobe: latch header and load outgoing slots |
| shift | input | 1 | Shift strobe: move one bit |
| update | input | 1 | Update strobe: commit a completed exchange |
| tdi | input | 1 | Serial data from host |
| tdo | output | 1 | Serial data to host |
| rd_en | input | 1 | Target read strobe for the receive FIFO |
| rd_data | output | 8 | Oldest byte of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO is empty |
| wr_en | input | 1 | Target write strobe for the transmit FIFO |
| wr_data | input | 8 | Byte written to the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO is full |

## Verification
The bench offers more host bytes than the reported free space, and it also sends a host count above 8. A design that clipped to the wrong limit would leave extra or missing bytes in the receive stream. It cuts a scan short after 30 bits and then checks that the same transmit bytes appear again in the next full scan. A design that popped at capture, or on any update, would lose them. It overfills the transmit FIFO, reads from an empty receive FIFO and strobes while the module is deselected. Each of these must leave the next header and the byte streams exactly as the scoreboard predicts.

// File: rtl/jtag_char_port.sv
module jtag_char_port #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       capture,
  input  logic       shift,
  input  logic       update,
  input  logic       tdi,
  output logic       tdo,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rx_empty,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       tx_full
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int SLOTS = 8;
  localparam int SW    = (SLOTS + 1) * 8;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [CW-1:0] tx_cnt, rx_cnt, rx_free;
  logic [SW-1:0] sr;
  logic [6:0]    nbits;
  logic          armed;
  logic [3:0]    avail_now, free_now, avail_q, free_q, lim, host_n, accept;
  logic          push, pop, cap_ok, sh_ok, commit;

  assign rx_empty  = (rx_cnt == '0);
  assign tx_full   = (tx_cnt == CW'(DEPTH));
  assign rd_data   = rx_mem[rx_rp];
  assign tdo       = sel & sr[0];

  assign push      = wr_en & ~tx_full;
  assign pop       = rd_en & ~rx_empty;
  assign cap_ok    = sel & capture;
  assign sh_ok     = sel & shift & armed & ~capture;
  assign commit    = sel & update & armed & ~capture & ~shift & (nbits == 7'(SW));

  assign rx_free   = CW'(DEPTH) - rx_cnt;
  assign avail_now = (tx_cnt > CW'(SLOTS)) ? 4'd8 : tx_cnt[3:0];
  assign free_now  = (rx_free > CW'(15)) ? 4'd15 : rx_free[3:0];

  assign host_n    = sr[7:4];
  assign lim       = (free_q > 4'd8) ? 4'd8 : free_q;
  assign accept    = (host_n < lim) ? host_n : lim;

  // shift register, bit counter, header latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      nbits   <= '0;
      armed   <= 1'b0;
      avail_q <= '0;
      free_q  <= '0;
    end else if (cap_ok) begin
      avail_q <= avail_now;
      free_q  <= free_now;
      armed   <= 1'b1;
      nbits   <= '0;
      sr[7:0] <= {avail_now, free_now};
      for (int i = 0; i < SLOTS; i++)
        sr[8 + 8*i +: 8] <= (4'(i) < avail_now) ? tx_mem[tx_rp + AW'(i)] : 8'h00;
    end else if (sh_ok) begin
      sr <= {tdi, sr[SW-1:1]};
      if (nbits != 7'h7f) nbits <= nbits + 7'd1;
    end else if (sel & update) begin
      armed <= 1'b0;
    end
  end

  // storage arrays
  always_ff @(posedge clk) begin
    if (push) tx_mem[tx_wp] <= wr_data;
    if (commit)
      for (int i = 0; i < SLOTS; i++)
        if (4'(i) < accept) rx_mem[rx_wp + AW'(i)] <= sr[8 + 8*i +: 8];
  end

  // pointers and counts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
    end else begin
      if (push) tx_wp <= tx_wp + AW'(1);
      if (commit) tx_rp <= tx_rp + AW'(avail_q);
      tx_cnt <= tx_cnt + CW'(push) - (commit ? CW'(avail_q) : CW'(0));
      if (pop) rx_rp <= rx_rp + AW'(1);
      if (commit) rx_wp <= rx_wp + AW'(accept);
      rx_cnt <= rx_cnt + (commit ? CW'(accept) : CW'(0)) - CW'(pop);
    end
  end

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH)); // R6
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH)); // R6
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && wr_en && !commit |=> tx_cnt == $past(tx_cnt)); // R6
  AST_EMPTY_READ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty && rd_en && !commit |=> rx_empty); // R6
  AST_HDR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ok |=> sr[7:4] <= 4'd8 && sr[7:4] <= tx_cnt); // R1
  AST_ACCEPT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> CW'(accept) <= rx_free); // R3
  AST_SHORT_SCAN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    sel && update && nbits != 7'(SW) && !wr_en && !rd_en |=> $stable(tx_cnt) && $stable(rx_cnt)); // R4
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel && !wr_en && !rd_en |=> $stable(tx_cnt) && $stable(rx_cnt)); // R7
  AST_DESELECT_TDO: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !tdo); // R7
endmodule

// File: tb/tb_jtag_char_port.sv
module tb_jtag_char_port;
  localparam int DEPTH = 8;
  logic clk = 0, rst_n = 0;
  logic sel = 0, capture = 0, shift = 0, update = 0, tdi = 0;
  logic tdo, rd_en = 0, rx_empty, wr_en = 0, tx_full;
  logic [7:0] rd_data, wr_data = 0;
  int total = 0, bad = 0;
  logic [7:0] exp_rx[$];
  logic [7:0] tx_model[$];

  always #2 clk = ~clk;

  jtag_char_port #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  // monitor: pops expected host bytes as the target consumes them
  always @(negedge clk) if (rst_n && rd_en) begin
    if (rx_empty) chk(exp_rx.size() == 0, "R6 empty read", 72'(exp_rx.size()), 72'd0);
    else if (exp_rx.size() == 0) chk(1'b0, "R5 unexpected byte", 72'(rd_data), 72'h0);
    else begin
      logic [7:0] e;
      e = exp_rx.pop_front();
      chk(rd_data == e, "R5 R3 rx byte", 72'(rd_data), 72'(e));
    end
  end

  task automatic tgt_write(input logic [7:0] b);
    wr_en = 1; wr_data = b;
    if (tx_model.size() < DEPTH) tx_model.push_back(b);
    tick; wr_en = 0;
  endtask

  task automatic tgt_read; rd_en = 1; tick; rd_en = 0; endtask

  task automatic scan(input int n, input logic [63:0] bytes, input int len, input string tag);
    logic [71:0] inv, got, expv;
    int av, fr, acc;
    av = (tx_model.size() > 8) ? 8 : tx_model.size();
    fr = DEPTH - exp_rx.size(); if (fr > 15) fr = 15;
    expv = '0;
    expv[7:0] = {4'(av), 4'(fr)};
    for (int k = 0; k < av; k++) expv[8 + 8*k +: 8] = tx_model[k];
    inv = {bytes, 4'(n), 4'b0};
    got = '0;
    sel = 1; capture = 1; tick; capture = 0;
    for (int k = 0; k < len; k++) begin
      tdi = inv[k]; shift = 1;
      @(negedge clk); got[k] = tdo;
      @(posedge clk); #1;
    end
    shift = 0; update = 1; tick; update = 0;
    if (len == 72) begin
      chk(got[7:0] == expv[7:0], {tag, " R1 header"}, 72'(got[7:0]), 72'(expv[7:0]));
      chk(got == expv, {tag, " R2 slots"}, got, expv);
      for (int k = 0; k < av; k++) void'(tx_model.pop_front());
      acc = n; if (acc > fr) acc = fr; if (acc > 8) acc = 8;
      for (int k = 0; k < acc; k++) exp_rx.push_back(bytes[8*k +: 8]);
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick; tick; rst_n = 1; tick;
    chk(rx_empty == 1 && tx_full == 0 && tdo == 0, "R8 reset", {rx_empty, tx_full, tdo}, 3'b100);
    scan(0, 64'h0, 72, "empty");
    tgt_write(8'hA1); tgt_write(8'h5C); tgt_write(8'h0F);
    scan(5, 64'h00_00_00_55_44_33_22_11, 72, "3out5in");
    scan(8, 64'h88_77_66_C3_B2_A1_99_90, 72, "R3 clip to free");
    chk(rx_empty == 0, "R3 rx filled", 72'(rx_empty), 72'd0);
    for (int k = 0; k < 8; k++) tgt_read();
    chk(rx_empty == 1, "R5 drained", 72'(rx_empty), 72'd1);
    tgt_read();
    chk(rx_empty == 1, "R6 empty read", 72'(rx_empty), 72'd1);
    for (int k = 0; k < 10; k++) tgt_write(8'(8'h30 + k));
    chk(tx_full == 1, "R6 tx_full", 72'(tx_full), 72'd1);
    scan(15, 64'hF7_F6_F5_F4_F3_F2_F1_F0, 72, "R3 count15");
    chk(tx_full == 0, "R4 drained tx", 72'(tx_full), 72'd0);
    for (int k = 0; k < 8; k++) tgt_read();
    tgt_write(8'hDE); tgt_write(8'hAD);
    scan(2, 64'h0000_0000_0000_EEFF, 30, "R4 abort");
    scan(0, 64'h0, 72, "R4 after abort");
    tgt_write(8'h7E);
    sel = 0; capture = 1; tick; capture = 0;
    for (int k = 0; k < 72; k++) begin shift = 1; tdi = 1; tick; end
    shift = 0; update = 1; tick; update = 0;
    chk(tdo == 0, "R7 tdo low", 72'(tdo), 72'd0);
    scan(1, 64'h42, 72, "R7 after deselect");
    tgt_read();
    chk(rx_empty == 1, "R5 final empty", 72'(rx_empty), 72'd1);
    chk(exp_rx.size() == 0, "R5 all consumed", 72'(exp_rx.size()), 72'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule